// File: doc/BRIEF.md
# NAND Sector Single-Bit ECC Corrector

This block guards one NAND sector at a time with a 24-bit Hamming-style code. Data bytes stream in one per cycle. For every one of the twelve bits of the bit address (byte offset times eight plus bit index), the block keeps two parity bits. One covers the positions where that address bit is 1. The other covers the positions where it is 0. The current code is always visible on a 24-bit output. On request, the code is also sent out as three bytes for storage next to the sector.

On a read, the freshly computed code is compared with the code that was stored beside the data. The result sorts the difference (the syndrome) into one of four outcomes:

- no error;
- a single flipped data bit, given as a byte offset and a one-hot bit mask;
- a single flipped bit inside the stored code, where the data needs no change;
- an uncorrectable error.

The block only reports the location to flip. Holding the sector and rewriting memory belong to the surrounding logic.

Top module: `nand_ecc_corrector`

## Requirements
- R1: After reset, `code_o` reads 24'hFFFFFF (empty accumulator), and `res_valid_o` and `code_byte_vld_o` are low.
- R2: With address a = offset*8 + bit over the accepted bytes since the last clear, bit j of the high half (code bits 23:12) holds the inverse of the XOR of address bit j over all set data bits. Bit j of the low half (code bits 11:0) holds the inverse of the XOR of the inverted address bit j over the same bits.
- R3: A full sector of 8'hFF bytes gives `code_o` = 24'hFFFFFF, so an erased sector with an erased code compares clean.
- R4: Once SECTOR_BYTES bytes have been accepted, further bytes are ignored until the next clear, and `code_o` does not change.
- R5: `clr_i` empties the accumulator and restarts the byte offset at 0. A byte offered in the same cycle as `clr_i` is dropped.
- R6: A pulse on `emit_i` while idle puts the three code bytes on `code_byte_o` on the next three cycles, bits 7:0 first, then 15:8, then 23:16, with `code_byte_vld_o` high for exactly those cycles.
- R7: `emit_i` while bytes are still being emitted is ignored.
- R8: `res_valid_o` is high exactly in the cycle after `cmp_i`. The syndrome is `stored_code_i` XOR `code_o` in the `cmp_i` cycle.
- R9: A zero syndrome gives status 0 (clean), with offset 0 and mask 0.
- R10: If the syndrome's low 12 bits XOR its high 12 bits are all ones, the status is 1 (data bit fixed). The offset is syndrome bits 23:15, and the mask is 1 shifted left by syndrome bits 14:12.
- R11: A syndrome of the R10 form whose offset is SECTOR_BYTES or more gives status 3 (uncorrectable).
- R12: A syndrome with exactly one bit set gives status 2 (code bit fixed), with offset 0 and mask 0.
- R13: Any other nonzero syndrome gives status 3, with offset 0 and mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Restart accumulation for a new sector |
| byte_vld_i | input | 1 | `byte_i` carries the next sector byte |
| byte_i | input | 8 | Sector data byte |
| code_o | output | 24 | Packed, inverted code of the bytes accepted so far |
| emit_i | input | 1 | Start sending the code as three bytes |
| code_byte_vld_o | output | 1 | `code_byte_o` is valid |
| code_byte_o | output | 8 | Code byte, least significant first |
| cmp_i | input | 1 | Compare `stored_code_i` with the computed code |
| stored_code_i | input | 24 | Code read back from storage |
| res_valid_o | output | 1 | Result valid, one cycle after `cmp_i` |
| res_status_o | output | 2 | 0 clean, 1 data fixed, 2 code fixed, 3 uncorrectable |
| res_offset_o | output | 9 | Byte offset of the bit to flip |
| res_mask_o | output | 8 | One-hot mask of the bit to flip |

## Verification
The bench builds two copies side by side on the same stream. One uses the default 512-byte sector. The other uses a 300-byte sector. With 512 bytes, every offset the code can carry is inside the sector, so the out-of-range rule cannot be reached. The 300-byte copy makes that rule reachable through offsets 300 to 511. It also exercises the ignore-after-full rule on every full stream, because the last 212 bytes must leave its code untouched. Syndromes are made both by real bit flips in the data and by XOR patterns applied to the stored code. This way, boundary offsets 0, 299 and 511 are reached without streaming a sector for each.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    // Code geometry: a 9-bit byte offset plus a 3-bit bit index
    localparam int OFF_W      = 9;
    localparam int BIT_W      = 3;
    localparam int ADDR_W     = OFF_W + BIT_W;
    localparam int CODE_W     = 2 * ADDR_W;
    localparam int CODE_BYTES = CODE_W / 8;
    // Raw parity word: each half sits in a 16-bit span, upper bits reserved
    localparam int HALF_SPAN  = 16;
    localparam int RAW_W      = 2 * HALF_SPAN;

    typedef logic [ADDR_W-1:0] half_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [RAW_W-1:0]  raw_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [7:0]        byte_t;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_DATA_FIX = 2'd1,
        ST_CODE_FIX = 2'd2,
        ST_UNCORR   = 2'd3
    } ecc_status_e;

    // ones: parity where the address bit is 1; zeros: where it is 0
    typedef struct packed {
        half_t ones;
        half_t zeros;
    } parity_t;

    typedef struct packed {
        ecc_status_e status;
        off_t        offset;
        byte_t       mask;
    } ecc_result_t;

    // Place both halves into the 32-bit raw layout with reserved bits zero
    function automatic raw_t raw_word(parity_t p);
        raw_t r;
        r = '0;
        r[ADDR_W-1:0]          = p.zeros;
        r[HALF_SPAN +: ADDR_W] = p.ones;
        return r;
    endfunction

    // Drop reserved bits, join the halves, invert so erased flash is valid
    function automatic code_t fold_code(raw_t r);
        code_t c;
        c = {r[HALF_SPAN +: ADDR_W], r[ADDR_W-1:0]};
        return ~c;
    endfunction

    // Parity of the data bits whose bit index has bit k equal to v
    function automatic logic col_parity(byte_t d, int k, logic v);
        logic p;
        p = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (((i >> k) & 1) == int'(v)) begin
                p = p ^ d[i];
            end
        end
        return p;
    endfunction

    function automatic byte_t bit_mask(logic [BIT_W-1:0] idx);
        return byte_t'(1) << idx;
    endfunction

endpackage

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    byte_vld,
    input  byte_t   data,
    output parity_t par
);

    localparam int CNT_W = $clog2(SECTOR_BYTES + 1);

    logic [CNT_W-1:0] cnt_q;
    parity_t          par_q;
    logic             take;
    logic             full;
    off_t             off;
    logic             row_p;
    half_t            inc_ones;
    half_t            inc_zeros;

    assign full  = (cnt_q == CNT_W'(SECTOR_BYTES));
    assign take  = byte_vld && !clr && !full;
    assign off   = off_t'(cnt_q);
    assign row_p = ^data;

    // Per address bit: low bits select within the byte, high bits by offset
    for (genvar k = 0; k < ADDR_W; k++) begin : g_addr
        if (k < BIT_W) begin : g_col
            assign inc_ones[k]  = col_parity(data, k, 1'b1);
            assign inc_zeros[k] = col_parity(data, k, 1'b0);
        end else begin : g_row
            assign inc_ones[k]  = row_p &  off[k-BIT_W];
            assign inc_zeros[k] = row_p & ~off[k-BIT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            par_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            par_q.ones  <= par_q.ones  ^ inc_ones;
            par_q.zeros <= par_q.zeros ^ inc_zeros;
            cnt_q       <= cnt_q + 1'b1;
        end
    end

    assign par = par_q;

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(SECTOR_BYTES));

    a_r4_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> $stable(par_q));

    a_r5_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (par_q == '0 && cnt_q == '0));

endmodule

// File: rtl/nand_ecc_pack.sv
module nand_ecc_pack
    import nand_ecc_pkg::*;
(
    input  parity_t par,
    output code_t   code
);

    raw_t raw;

    assign raw  = raw_word(par);
    assign code = fold_code(raw);

endmodule

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmp,
    input  code_t       calc,
    input  code_t       stored,
    output logic        res_vld,
    output ecc_result_t res
);

    code_t       syn;
    half_t       lo;
    half_t       hi;
    logic        pair_ok;
    logic        in_range;
    ecc_result_t res_d;
    ecc_result_t res_q;
    logic        vld_q;

    assign syn      = calc ^ stored;
    assign lo       = syn[ADDR_W-1:0];
    assign hi       = syn[CODE_W-1:ADDR_W];
    assign pair_ok  = &(lo ^ hi);
    assign in_range = int'(hi[ADDR_W-1:BIT_W]) < SECTOR_BYTES;

    always_comb begin
        res_d.status = ST_CLEAN;
        res_d.offset = '0;
        res_d.mask   = '0;
        if (syn != '0) begin
            if (pair_ok) begin
                if (in_range) begin
                    res_d.status = ST_DATA_FIX;
                    res_d.offset = hi[ADDR_W-1:BIT_W];
                    res_d.mask   = bit_mask(hi[BIT_W-1:0]);
                end else begin
                    res_d.status = ST_UNCORR;
                end
            end else if ($onehot(syn)) begin
                res_d.status = ST_CODE_FIX;
            end else begin
                res_d.status = ST_UNCORR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= cmp;
            if (cmp) begin
                res_q <= res_d;
            end
        end
    end

    assign res_vld = vld_q;
    assign res     = res_q;

    a_r8_valid_after_cmp: assert property (@(posedge clk) disable iff (rst)
        cmp |=> vld_q);

    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !cmp |=> !vld_q);

    a_r10_mask_onehot: assert property (@(posedge clk) disable iff (rst)
        (vld_q && res_q.status == ST_DATA_FIX) |-> $countones(res_q.mask) == 1);

    a_r11_offset_in_sector: assert property (@(posedge clk) disable iff (rst)
        (vld_q && res_q.status == ST_DATA_FIX) |-> int'(res_q.offset) < SECTOR_BYTES);

    a_r13_no_location_unless_fix: assert property (@(posedge clk) disable iff (rst)
        (vld_q && res_q.status != ST_DATA_FIX) |-> (res_q.offset == '0 && res_q.mask == '0));

endmodule

// File: rtl/nand_ecc_emit.sv
module nand_ecc_emit
    import nand_ecc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  emit,
    input  code_t code,
    output logic  vld,
    output byte_t dout
);

    localparam int IDX_W = $clog2(CODE_BYTES);

    code_t            shadow_q;
    logic [IDX_W-1:0] idx_q;
    logic             busy_q;
    byte_t            lanes [CODE_BYTES];

    for (genvar b = 0; b < CODE_BYTES; b++) begin : g_lane
        assign lanes[b] = shadow_q[8*b +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            idx_q    <= '0;
            busy_q   <= 1'b0;
        end else if (emit && !busy_q) begin
            shadow_q <= code;
            idx_q    <= '0;
            busy_q   <= 1'b1;
        end else if (busy_q) begin
            if (idx_q == IDX_W'(CODE_BYTES - 1)) begin
                idx_q  <= '0;
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign vld  = busy_q;
    assign dout = lanes[idx_q];

    a_r6_start_at_low_byte: assert property (@(posedge clk) disable iff (rst)
        (emit && !busy_q) |=> (busy_q && idx_q == '0));

    a_r6_index_in_range: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> int'(idx_q) < CODE_BYTES);

    a_r7_busy_keeps_shadow: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(shadow_q));

endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr_i,
    input  logic        byte_vld_i,
    input  logic [7:0]  byte_i,
    output logic [23:0] code_o,
    input  logic        emit_i,
    output logic        code_byte_vld_o,
    output logic [7:0]  code_byte_o,
    input  logic        cmp_i,
    input  logic [23:0] stored_code_i,
    output logic        res_valid_o,
    output logic [1:0]  res_status_o,
    output logic [8:0]  res_offset_o,
    output logic [7:0]  res_mask_o
);

    parity_t     par;
    code_t       code;
    ecc_result_t res;

    nand_ecc_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_i),
        .byte_vld (byte_vld_i),
        .data     (byte_i),
        .par      (par)
    );

    nand_ecc_pack u_pack (
        .par  (par),
        .code (code)
    );

    nand_ecc_emit u_emit (
        .clk  (clk),
        .rst  (rst),
        .emit (emit_i),
        .code (code),
        .vld  (code_byte_vld_o),
        .dout (code_byte_o)
    );

    nand_ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_classify (
        .clk     (clk),
        .rst     (rst),
        .cmp     (cmp_i),
        .calc    (code),
        .stored  (stored_code_i),
        .res_vld (res_valid_o),
        .res     (res)
    );

    assign code_o       = code;
    assign res_status_o = res.status;
    assign res_offset_o = res.offset;
    assign res_mask_o   = res.mask;

endmodule

// File: tb/test_nand_ecc_corrector.sv
`timescale 1ns/1ps
module test_nand_ecc_corrector;

    localparam int SHORT_BYTES = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        emit_i = 1'b0;
    logic        cmp_i = 1'b0;
    logic [23:0] m_stored = '0;
    logic [23:0] s_stored = '0;

    logic [23:0] m_code, s_code;
    logic        m_bvld, s_bvld;
    logic [7:0]  m_byte, s_byte;
    logic        m_rv, s_rv;
    logic [1:0]  m_st, s_st;
    logic [8:0]  m_off, s_off;
    logic [7:0]  m_mask, s_mask;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] mem [512];

    always #2 clk = ~clk;

    nand_ecc_corrector i_nand_ecc_corrector (
        .clk(clk), .rst(rst), .clr_i(clr_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .code_o(m_code), .emit_i(emit_i), .code_byte_vld_o(m_bvld), .code_byte_o(m_byte),
        .cmp_i(cmp_i), .stored_code_i(m_stored), .res_valid_o(m_rv),
        .res_status_o(m_st), .res_offset_o(m_off), .res_mask_o(m_mask)
    );

    nand_ecc_corrector #(.SECTOR_BYTES(SHORT_BYTES)) i_nand_ecc_corrector_s300 (
        .clk(clk), .rst(rst), .clr_i(clr_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .code_o(s_code), .emit_i(emit_i), .code_byte_vld_o(s_bvld), .code_byte_o(s_byte),
        .cmp_i(cmp_i), .stored_code_i(s_stored), .res_valid_o(s_rv),
        .res_status_o(s_st), .res_offset_o(s_off), .res_mask_o(s_mask)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Code from the bit-address definition over the first n bytes of mem
    function automatic logic [23:0] model_code(int n);
        logic [11:0] hi, lo, a;
        hi = '0;
        lo = '0;
        for (int o = 0; o < n; o++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[o][b]) begin
                    a  = 12'(o * 8 + b);
                    hi = hi ^ a;
                    lo = lo ^ ~a;
                end
            end
        end
        return ~{hi, lo};
    endfunction

    function automatic logic [23:0] synd(int off, int bitn);
        logic [11:0] a;
        a = 12'(off * 8 + bitn);
        return {a, ~a};
    endfunction

    task automatic do_clear();
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    task automatic stream(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld_i = 1'b1;
            byte_i     = mem[i];
        end
        @(negedge clk);
        byte_vld_i = 1'b0;
    endtask

    // Leaves the caller at the negedge where the results are valid
    task automatic compare(logic [23:0] st_m, logic [23:0] st_s);
        @(negedge clk);
        cmp_i    = 1'b1;
        m_stored = st_m;
        s_stored = st_s;
        @(negedge clk);
        cmp_i = 1'b0;
    endtask

    task automatic expect_res(string req, logic [1:0] st, logic [8:0] off, logic [7:0] mk);
        check({req, " main valid"}, m_rv, 1'b1);
        check({req, " main status"}, m_st, st);
        check({req, " main offset"}, m_off, off);
        check({req, " main mask"}, m_mask, mk);
    endtask

    task automatic expect_short(string req, logic [1:0] st, logic [8:0] off, logic [7:0] mk);
        check({req, " short valid"}, s_rv, 1'b1);
        check({req, " short status"}, s_st, st);
        check({req, " short offset"}, s_off, off);
        check({req, " short mask"}, s_mask, mk);
    endtask

    task automatic t_reset();
        check("R1 code after reset", m_code, 24'hFFFFFF);
        check("R1 result valid low", m_rv, 1'b0);
        check("R1 emit valid low", m_bvld, 1'b0);
    endtask

    task automatic t_erased();
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        do_clear();
        stream(512);
        check("R3 erased main code", m_code, 24'hFFFFFF);
        check("R3 erased short code", s_code, model_code(SHORT_BYTES));
        compare(24'hFFFFFF, model_code(SHORT_BYTES));
        expect_res("R3 R9 erased clean", 2'd0, 9'd0, 8'h00);
        @(negedge clk);
        check("R8 valid lasts one cycle", m_rv, 1'b0);
    endtask

    task automatic t_pattern();
        logic [23:0] c;
        for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 13) ^ 8'(i >> 3);
        do_clear();
        stream(512);
        c = model_code(512);
        check("R2 pattern main code", m_code, c);
        check("R2 R4 pattern short code", s_code, model_code(SHORT_BYTES));
        // emission, with a second request while busy
        @(negedge clk);
        emit_i = 1'b1;
        @(negedge clk);
        check("R6 byte0 valid", m_bvld, 1'b1);
        check("R6 byte0", m_byte, c[7:0]);
        @(negedge clk);
        emit_i = 1'b0;
        check("R7 byte1 after busy emit", m_byte, c[15:8]);
        @(negedge clk);
        check("R6 byte2", m_byte, c[23:16]);
        check("R6 byte2 valid", m_bvld, 1'b1);
        @(negedge clk);
        check("R6 R7 valid drops after three", m_bvld, 1'b0);
    endtask

    task automatic t_extra();
        logic [23:0] c;
        c = model_code(512);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            byte_vld_i = 1'b1;
            byte_i     = 8'(8'h5A + i);
        end
        @(negedge clk);
        byte_vld_i = 1'b0;
        check("R4 bytes past sector ignored", m_code, c);
    endtask

    task automatic t_data_flip();
        logic [23:0] orig;
        orig = model_code(512);
        mem[300] = mem[300] ^ 8'h08;
        do_clear();
        stream(512);
        compare(orig, model_code(SHORT_BYTES));
        expect_res("R10 real flip at 300 bit 3", 2'd1, 9'd300, 8'h08);
        expect_short("R9 short clean", 2'd0, 9'd0, 8'h00);
        mem[300] = mem[300] ^ 8'h08;
        do_clear();
        stream(512);
    endtask

    task automatic t_crafted();
        logic [23:0] cm, cs;
        cm = model_code(512);
        cs = model_code(SHORT_BYTES);
        compare(cm ^ synd(0, 0), cs);
        expect_res("R10 offset 0 bit 0", 2'd1, 9'd0, 8'h01);
        compare(cm ^ synd(511, 7), cs);
        expect_res("R10 offset 511 bit 7", 2'd1, 9'd511, 8'h80);
        compare(cm ^ 24'h000001, cs ^ 24'h800000);
        expect_res("R12 code bit 0", 2'd2, 9'd0, 8'h00);
        expect_short("R12 code bit 23", 2'd2, 9'd0, 8'h00);
        compare(cm ^ synd(5, 1) ^ synd(9, 2), cs ^ synd(400, 2));
        expect_res("R13 double flip", 2'd3, 9'd0, 8'h00);
        expect_short("R11 offset 400 past sector", 2'd3, 9'd0, 8'h00);
        compare(cm ^ 24'h000007, cs ^ synd(299, 6));
        expect_res("R13 three code bits", 2'd3, 9'd0, 8'h00);
        expect_short("R11 offset 299 last byte", 2'd1, 9'd299, 8'h40);
    endtask

    task automatic t_clear();
        stream(100);
        do_clear();
        check("R5 clear empties", m_code, 24'hFFFFFF);
        stream(512);
        check("R5 restart after partial", m_code, model_code(512));
        @(negedge clk);
        clr_i      = 1'b1;
        byte_vld_i = 1'b1;
        byte_i     = 8'hFF;
        @(negedge clk);
        clr_i      = 1'b0;
        byte_vld_i = 1'b0;
        check("R5 same-cycle byte dropped", m_code, 24'hFFFFFF);
        stream(512);
        check("R5 offsets restart at 0", m_code, model_code(512));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_erased();
        t_pattern();
        t_extra();
        t_data_flip();
        t_crafted();
        t_clear();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-R13 run: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule